// File: doc/BRIEF.md
# Lockable Four-Way Cache Controller

This block is a four-way set-associative cache placed between a 32-bit processor port and a simple word-wide memory port. It keeps tags, valid bits and line data in internal registers. A read that hits is answered in the same cycle it is presented, which lets the processor take one word per cycle. A read that misses fetches the whole eight-word line from memory and installs it in a victim way. The requested word is returned once the line is complete.

Writes always go out to memory. A write that hits also updates the cached copy. A write that misses does not bring the line in. Two configuration inputs control placement. One picks the replacement policy: a pseudo-random choice or a rotating pointer. The other gives a lock boundary, so that the lowest ways keep critical code resident and are never chosen as victims. When every way is locked, misses are served straight from memory. A single-cycle invalidate input empties the whole cache.

The address splits into these fields, with the default of four sets:
- byte offset: `addr[1:0]`, ignored by the cache
- word within the line: `addr[4:2]`
- set index: `addr[6:5]`
- tag: `addr[31:7]`

Top module: `lockway_cache`

## Requirements
- R1: While reset is held and after it is released, `cpu_ack` and `mem_req` stay low until a request arrives, and no line is valid, so the first read of any address misses.
- R2: A read that hits asserts `cpu_ack` in the same cycle as `cpu_req`, returns the cached word on `cpu_rdata` and makes no memory access.
- R3: A read miss issues eight memory reads to the words of its line, at word offsets 0 through 7 in order, one per `mem_ack`. `cpu_ack` is raised in the cycle after the last word, with the requested word. A fill with a memory that acknowledges at once takes nine cycles from acceptance to acknowledge.
- R4: Every write produces exactly one memory write with the request's address and data. `cpu_ack` is raised in the cycle of `mem_ack`. On a hit the cached word is replaced, so a later read hits and returns the new value.
- R5: A write that misses allocates nothing, so a following read of that address misses.
- R6: With `cfg_lock` = L, ways 0 to L-1 are never chosen as victims. Values above 4 act as 4.
- R7: With all four ways locked, a read miss makes a single memory read. `cpu_ack` is raised in the cycle of `mem_ack` with `mem_rdata`, and no line is installed, so a repeated read misses again.
- R8: Round-robin (`cfg_rr` = 1) uses a two-bit pointer that resets to 0. The victim is the pointer, or L if the pointer is below L. After every allocation, under either policy, the pointer becomes the victim plus 1, modulo 4.
- R9: Pseudo-random (`cfg_rr` = 0) picks way L + (s mod (4-L)), where s is the 16-bit state in the cycle the miss is accepted. The state register is loaded with 16'hACE1 at reset. Every clock it shifts left, and the new bit 0 is the XOR of bits 15, 13, 12 and 10.
- R10: When `inv_all` is high while the controller is idle, every valid bit is cleared in that cycle, and a `cpu_req` in the same cycle is not accepted.
- R11: Once raised, `mem_req`, `mem_we` and `mem_addr` stay stable until `mem_ack`.
- R12: `cpu_ack` is only asserted while `cpu_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_ack | output | 1 | Request completed this cycle |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` on reads |
| cfg_rr | input | 1 | 1 = round-robin, 0 = pseudo-random |
| cfg_lock | input | 3 | Number of locked ways, counted from way 0 |
| inv_all | input | 1 | Invalidate every line |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory accepted the access, read data valid |
| mem_rdata | input | 32 | Memory read data |

## Verification
The assertions check on every cycle that the memory request holds steady until accepted and that acknowledges only appear under a live request. They also check that each write acknowledge coincides with an accepted memory write, that fill words advance by one within the line, and that a fill never targets a locked way.

Which way is replaced, and whether a later read hits or misses, can only be shown by the scenarios. The bench model tracks tags, the rotating pointer and the pseudo-random state. It predicts hit, fill or uncached service with exact memory-read counts and latencies, which exposes a wrong victim, a lost lock or a missing invalidate.

// File: rtl/lockway_pkg.sv
package lockway_pkg;
  localparam int ADDR_W    = 32;
  localparam int DATA_W    = 32;
  localparam int WAYS      = 4;
  localparam int WAY_W     = $clog2(WAYS);
  localparam int WORDS     = 8;
  localparam int OFF_W     = $clog2(WORDS);
  localparam int LF_W      = 16;
  localparam logic [LF_W-1:0] LF_SEED = 16'hACE1;
  localparam logic [LF_W-1:0] LF_TAPS = 16'hB400;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FILL,
    S_DONE,
    S_WRITE,
    S_UNC
  } lkc_state_e;
endpackage

// File: rtl/lockway_lfsr.sv
module lockway_lfsr #(
  parameter int              W    = 16,
  parameter logic [W-1:0]    TAPS = 16'hB400,
  parameter logic [W-1:0]    SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);
  logic [W-1:0] state_d;

  always_comb begin
    state_d = {state[W-2:0], ^(state & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED;
    else        state <= state_d;
  end
endmodule

// File: rtl/lockway_victim.sv
module lockway_victim
  import lockway_pkg::*;
(
  input  logic [WAY_W:0]   lock_n,
  input  logic             policy_rr,
  input  logic [WAY_W-1:0] rr_ptr,
  input  logic [LF_W-1:0]  rnd,
  output logic [WAY_W-1:0] victim,
  output logic             all_locked
);
  logic [WAY_W:0]   free_n;
  logic [WAY_W:0]   div_n;
  logic [LF_W-1:0]  off;
  logic [WAY_W-1:0] rand_way;
  logic [WAY_W-1:0] rr_way;

  always_comb begin
    free_n     = (WAY_W+1)'(WAYS) - lock_n;
    all_locked = (free_n == '0);
    div_n      = all_locked ? (WAY_W+1)'(1) : free_n;
    off        = rnd % LF_W'(div_n);
    rand_way   = WAY_W'(LF_W'(lock_n) + off);
    rr_way     = ({1'b0, rr_ptr} < lock_n) ? lock_n[WAY_W-1:0] : rr_ptr;
    victim     = policy_rr ? rr_way : rand_way;
  end
endmodule

// File: rtl/lockway_store.sv
module lockway_store
  import lockway_pkg::*;
#(
  parameter int SETS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-3:0] lk_waddr,
  input  logic              inv_en,
  input  logic              wr_en,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [OFF_W-1:0]  wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tag_en,
  input  logic [WAY_W-1:0]  tag_way,
  output logic              hit,
  output logic [WAY_W-1:0]  hit_way,
  output logic [DATA_W-1:0] rdata
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - 2 - OFF_W - IDX_W;

  logic [DATA_W-1:0] data_q [SETS][WAYS][WORDS];
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [WAYS-1:0]   val_q  [SETS];
  logic [WAYS-1:0]   hv;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic [OFF_W-1:0] word;

  assign word = lk_waddr[OFF_W-1:0];
  assign idx  = lk_waddr[OFF_W +: IDX_W];
  assign tag  = lk_waddr[ADDR_W-3 -: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hv[w] = val_q[idx][w] && (tag_q[idx][w] == tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hv[w]) hit_way = w[WAY_W-1:0];
    end
    hit   = |hv;
    rdata = data_q[idx][hit_way][word];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) val_q[s] <= '0;
    end else if (inv_en) begin
      for (int s = 0; s < SETS; s++) val_q[s] <= '0;
    end else if (tag_en) begin
      val_q[idx][tag_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (tag_en) tag_q[idx][tag_way] <= tag;
  end

  always_ff @(posedge clk) begin
    if (wr_en) data_q[idx][wr_way][wr_word] <= wr_data;
  end
endmodule

// File: rtl/lockway_cache.sv
module lockway_cache
  import lockway_pkg::*;
#(
  parameter int SETS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ack,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              cfg_rr,
  input  logic [WAY_W:0]    cfg_lock,
  input  logic              inv_all,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int LINE_LO = 2 + OFF_W;

  lkc_state_e        st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [WAY_W-1:0]  vict_q, vict_d;
  logic [WAY_W-1:0]  hitw_q, hitw_d;
  logic              hit_q, hit_d;
  logic [OFF_W-1:0]  cnt_q, cnt_d;
  logic [WAY_W-1:0]  rr_q, rr_d;

  logic [ADDR_W-1:0] lk_addr;
  logic              lk_hit;
  logic [WAY_W-1:0]  lk_way;
  logic [DATA_W-1:0] lk_rdata;
  logic [WAY_W:0]    lock_eff;
  logic [WAY_W-1:0]  victim;
  logic              all_locked;
  logic [LF_W-1:0]   rnd;
  logic              inv_en, wr_en, tag_en;
  logic [WAY_W-1:0]  wr_way;
  logic [OFF_W-1:0]  wr_word;
  logic [DATA_W-1:0] wr_data;
  logic              fill_active;

  assign lock_eff    = (cfg_lock > (WAY_W+1)'(WAYS)) ? (WAY_W+1)'(WAYS) : cfg_lock;
  assign lk_addr     = (st_q == S_IDLE) ? cpu_addr : addr_q;
  assign fill_active = (st_q == S_FILL);

  lockway_lfsr #(.W(LF_W), .TAPS(LF_TAPS), .SEED(LF_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .state(rnd)
  );

  lockway_victim u_victim (
    .lock_n(lock_eff), .policy_rr(cfg_rr), .rr_ptr(rr_q), .rnd(rnd),
    .victim(victim), .all_locked(all_locked)
  );

  lockway_store #(.SETS(SETS)) u_store (
    .clk(clk), .rst_n(rst_n), .lk_waddr(lk_addr[ADDR_W-1:2]), .inv_en(inv_en),
    .wr_en(wr_en), .wr_way(wr_way), .wr_word(wr_word), .wr_data(wr_data),
    .tag_en(tag_en), .tag_way(vict_q), .hit(lk_hit), .hit_way(lk_way),
    .rdata(lk_rdata)
  );

  always_comb begin
    st_d      = st_q;
    addr_d    = addr_q;
    wdata_d   = wdata_q;
    vict_d    = vict_q;
    hitw_d    = hitw_q;
    hit_d     = hit_q;
    cnt_d     = cnt_q;
    rr_d      = rr_q;
    cpu_ack   = 1'b0;
    cpu_rdata = lk_rdata;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = addr_q;
    mem_wdata = wdata_q;
    inv_en    = 1'b0;
    wr_en     = 1'b0;
    tag_en    = 1'b0;
    wr_way    = vict_q;
    wr_word   = cnt_q;
    wr_data   = mem_rdata;
    case (st_q)
      S_IDLE: begin
        if (inv_all) begin
          inv_en = 1'b1;
        end else if (cpu_req) begin
          addr_d  = cpu_addr;
          wdata_d = cpu_wdata;
          hit_d   = lk_hit;
          hitw_d  = lk_way;
          if (cpu_we) begin
            st_d = S_WRITE;
          end else if (lk_hit) begin
            cpu_ack = 1'b1;
          end else if (all_locked) begin
            st_d = S_UNC;
          end else begin
            st_d   = S_FILL;
            vict_d = victim;
            cnt_d  = '0;
            rr_d   = victim + 1'b1;
          end
        end
      end
      S_FILL: begin
        mem_req  = 1'b1;
        mem_addr = {addr_q[ADDR_W-1:LINE_LO], cnt_q, 2'b00};
        if (mem_ack) begin
          wr_en = 1'b1;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == OFF_W'(WORDS - 1)) begin
            tag_en = 1'b1;
            st_d   = S_DONE;
          end
        end
      end
      S_DONE: begin
        cpu_ack = 1'b1;
        st_d    = S_IDLE;
      end
      S_WRITE: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          cpu_ack = 1'b1;
          wr_en   = hit_q;
          wr_way  = hitw_q;
          wr_word = addr_q[2 +: OFF_W];
          wr_data = wdata_q;
          st_d    = S_IDLE;
        end
      end
      S_UNC: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          cpu_ack   = 1'b1;
          cpu_rdata = mem_rdata;
          st_d      = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      vict_q  <= '0;
      hitw_q  <= '0;
      hit_q   <= 1'b0;
      cnt_q   <= '0;
      rr_q    <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE) begin
        addr_q  <= addr_d;
        wdata_q <= wdata_d;
        vict_q  <= vict_d;
        hitw_q  <= hitw_d;
        hit_q   <= hit_d;
        rr_q    <= rr_d;
      end
      if (st_q == S_IDLE || st_q == S_FILL) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/lockway_cache_chk.sv
module lockway_cache_chk
  import lockway_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic              cpu_ack,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              fill_active,
  input logic [WAY_W-1:0]  vict_q,
  input logic [WAY_W:0]    lock_eff
);
  a_r12_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> cpu_req);

  a_r4_write_through: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && cpu_ack) |-> (mem_req && mem_we && mem_ack));

  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

  a_r3_fill_order: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack && !cpu_ack && mem_addr[2 +: OFF_W] != OFF_W'(WORDS - 1))
    |=> (mem_req && !mem_we && mem_addr[2 +: OFF_W] == $past(mem_addr[2 +: OFF_W]) + 1'b1));

  a_r6_victim_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_active && cpu_req) |-> ({1'b0, vict_q} >= lock_eff));
endmodule

bind lockway_cache lockway_cache_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
  .cpu_ack(cpu_ack), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .fill_active(fill_active), .vict_q(vict_q),
  .lock_eff(lock_eff)
);

// File: tb/lockway_cache_test.sv
`timescale 1ns/1ps
module lockway_cache_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we, cpu_ack;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic        cfg_rr;
  logic [2:0]  cfg_lock;
  logic        inv_all;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0, failures = 0;
  int rd_cnt = 0, wr_cnt = 0;
  bit slow = 0, tog = 0, done = 0;

  logic [31:0] mem_w [logic [31:0]];
  logic [24:0] mtag [4][4];
  bit          mval [4][4];
  int          rr_m;
  logic [15:0] lfsr_m;

  always #2 clk = ~clk;

  lockway_cache uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack),
    .cpu_rdata(cpu_rdata), .cfg_rr(cfg_rr), .cfg_lock(cfg_lock),
    .inv_all(inv_all), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    if (mem_w.exists(a)) return mem_w[a];
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
  endfunction

  function automatic logic [31:0] mk(input int t, input int s, input int w);
    return {t[24:0], s[1:0], w[2:0], 2'b00};
  endfunction

  // R9 state sequence, from the stated seed and feedback
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_m <= 16'hACE1;
    else        lfsr_m <= {lfsr_m[14:0], lfsr_m[15] ^ lfsr_m[13] ^ lfsr_m[12] ^ lfsr_m[10]};
  end

  // memory responder
  initial begin
    mem_ack = 0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      tog = ~tog;
      mem_ack = mem_req && (!slow || tog);
      mem_rdata = mem_rd(mem_addr);
      if (mem_ack) begin
        if (mem_we) begin
          mem_w[mem_addr] = mem_wdata;
          wr_cnt++;
        end else begin
          rd_cnt++;
        end
      end
    end
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic wait_ack(output int n);
    n = 0;
    forever begin
      #1;
      if (cpu_ack || done) break;
      n++;
      if (n > 300) break;
      @(negedge clk);
    end
  endtask

  task automatic rd(input logic [31:0] a, input string rq);
    int s, v, lk, kind, n, rc0;
    logic [24:0] t;
    logic [15:0] lf;
    bit h;
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = a;
    lf = lfsr_m; rc0 = rd_cnt;
    s = int'(a[6:5]); t = a[31:7]; h = 0; v = 0;
    for (int w = 0; w < 4; w++) if (mval[s][w] && mtag[s][w] == t) h = 1;
    lk = (cfg_lock > 4) ? 4 : int'(cfg_lock);
    if (h) kind = 0;
    else if (lk == 4) kind = 2;
    else begin
      kind = 1;
      if (cfg_rr) v = (rr_m < lk) ? lk : rr_m;
      else v = lk + int'(lf % 16'(4 - lk));
      mtag[s][v] = t; mval[s][v] = 1;
      rr_m = (v + 1) % 4;
    end
    wait_ack(n);
    check(cpu_ack, rq, "read ack", 32'(cpu_ack), 1);
    check(cpu_rdata == mem_rd(a), rq, "read data", cpu_rdata, mem_rd(a));
    check((rd_cnt - rc0) == (kind == 0 ? 0 : kind == 1 ? 8 : 1), rq, "memory reads",
          32'(rd_cnt - rc0), (kind == 0 ? 0 : kind == 1 ? 8 : 1));
    if (!slow)
      check(n == (kind == 0 ? 0 : kind == 1 ? 9 : 1), rq, "latency",
            32'(n), (kind == 0 ? 0 : kind == 1 ? 9 : 1));
    @(negedge clk);
    cpu_req = 0;
    #1;
    check(!cpu_ack, "R12", "ack without request", 32'(cpu_ack), 0);
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input string rq);
    int n, wc0;
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    wc0 = wr_cnt;
    wait_ack(n);
    check(cpu_ack, rq, "write ack", 32'(cpu_ack), 1);
    check((wr_cnt - wc0) == 1, rq, "memory writes", 32'(wr_cnt - wc0), 1);
    check(mem_rd(a) == d, rq, "memory word", mem_rd(a), d);
    if (!slow) check(n == 1, rq, "write latency", 32'(n), 1);
    @(negedge clk);
    cpu_req = 0; cpu_we = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
    cfg_rr = 1; cfg_lock = 0; inv_all = 0; rr_m = 0;
    for (int s = 0; s < 4; s++) for (int w = 0; w < 4; w++) begin mval[s][w] = 0; mtag[s][w] = '0; end
    repeat (3) @(negedge clk);
    #1;
    check(!cpu_ack && !mem_req, "R1", "idle during reset", {30'b0, cpu_ack, mem_req}, 0);
    @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    #1;
    check(!cpu_ack && !mem_req, "R1", "idle after reset", {30'b0, cpu_ack, mem_req}, 0);

    // R1 / R3: first reads miss and fill
    rd(mk(1, 0, 3), "R1");
    rd(mk(1, 0, 5), "R2");
    rd(mk(1, 0, 0), "R2");
    // R8: rotation across set 0
    rd(mk(2, 0, 0), "R8");
    rd(mk(3, 0, 1), "R8");
    rd(mk(4, 0, 7), "R3");
    rd(mk(5, 0, 2), "R8");
    rd(mk(1, 0, 3), "R8");
    rd(mk(3, 0, 1), "R2");
    // R4: write hit updates line
    wr(mk(3, 0, 4), 32'hCAFE_0001, "R4");
    rd(mk(3, 0, 4), "R4");
    // R5: write miss does not allocate
    wr(mk(9, 1, 2), 32'h0BAD_F00D, "R5");
    rd(mk(9, 1, 2), "R5");
    // R6: lock two ways
    for (int i = 0; i < 4; i++) rd(mk(20 + i, 2, i), "R6");
    cfg_lock = 2;
    for (int i = 0; i < 5; i++) rd(mk(30 + i, 2, i), "R6");
    for (int i = 0; i < 4; i++) rd(mk(20 + i, 2, i), "R6");
    // R9: pseudo-random victims
    cfg_rr = 0; cfg_lock = 1;
    for (int i = 0; i < 8; i++) rd(mk(40 + i, 3, i), "R9");
    for (int i = 0; i < 8; i++) rd(mk(40 + i, 3, 7 - i), "R9");
    cfg_lock = 3;
    for (int i = 0; i < 3; i++) rd(mk(50 + i, 3, 1), "R9");
    cfg_lock = 0;
    for (int i = 0; i < 5; i++) rd(mk(55 + i, 1, 6), "R9");
    // R11: slow memory
    slow = 1;
    rd(mk(60, 1, 3), "R11");
    wr(mk(60, 1, 3), 32'h1111_2222, "R11");
    rd(mk(60, 1, 3), "R11");
    rd(mk(61, 2, 5), "R11");
    slow = 0;
    // R7: all ways locked
    cfg_rr = 1; cfg_lock = 4;
    rd(mk(70, 2, 1), "R7");
    rd(mk(70, 2, 1), "R7");
    cfg_lock = 7;
    rd(mk(71, 2, 6), "R7");
    cfg_lock = 0;
    // R10: invalidate, with a simultaneous request refused
    rd(mk(80, 0, 0), "R10");
    rd(mk(80, 0, 0), "R10");
    @(negedge clk);
    inv_all = 1; cpu_req = 1; cpu_we = 0; cpu_addr = mk(80, 0, 0);
    #1;
    check(!cpu_ack, "R10", "request during invalidate", 32'(cpu_ack), 0);
    @(negedge clk);
    inv_all = 0; cpu_req = 0;
    for (int s = 0; s < 4; s++) for (int w = 0; w < 4; w++) mval[s][w] = 0;
    rd(mk(80, 0, 0), "R10");
    rd(mk(5, 0, 2), "R10");
    rd(mk(20, 2, 0), "R10");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule